// File: doc/BRIEF.md
# Downstream Credit Tracker

This block sits beside the rename stage of an out-of-order core and decides, once per cycle, how many instructions that stage may rename for one thread. It keeps the most recent free-entry counts reported by three downstream structures: the reorder buffer, the issue queue and the load/store queue. Those reports lag behind the pipeline. To correct for that, it keeps a count of instructions that have been renamed but not yet dispatched. It subtracts that count, less whatever was dispatched in the current report, from each stored free count to estimate the space that is really left.

The smallest of the three estimates limits the rename group. When the limit is zero or below, or smaller than the number of instructions waiting, the block asks the stage to stall. It also reports which structure caused the stall and counts the event in a per-structure saturating counter. All decision outputs are registered: a decision formed from the state and inputs of one cycle appears after the next rising clock edge.

Top module: `credit_tracker`

## Requirements
- R1: A synchronous active-high reset clears the three stored free counts, the in-flight count, the allowed count, the stall request, the cause code and all three event counters, and sets the reorder-buffer-empty flag to 1.
- R2: A stored free count takes its update value only in a cycle where that structure's update-valid input is 1, and otherwise keeps its value. The reorder-buffer-empty flag is captured together with the reorder buffer update and holds otherwise.
- R3: The reorder buffer and issue queue estimates are the stored free count minus (in-flight count minus the general dispatch count of the current cycle).
- R4: The load/store queue estimate subtracts (in-flight count minus the load/store dispatch count) and ignores the general dispatch count.
- R5: Each cycle the in-flight count becomes in-flight plus renamed minus dispatched (general count). The result is clamped to 0 below and to 2^CNT_W-1 above.
- R6: The limit is the smallest estimate, searched with strict less-than in the order reorder buffer, issue queue, load/store queue, so ties favour the earlier one. Cause codes are 0 none, 1 reorder buffer, 2 issue queue, 3 load/store queue.
- R7: With at least one instruction available and a limit of zero or below, the block allows 0, requests a stall and reports the limiting cause.
- R8: With a positive limit smaller than the available count, the block allows exactly the limit, requests a stall and reports the limiting cause.
- R9: With a limit at least the available count, the block allows the full available count, requests no stall and reports cause 0.
- R10: With no instructions available, the block allows 0, requests no stall, reports cause 0 and counts no event.
- R11: Each stalled decision adds one to the 16-bit event counter of its cause, in the same cycle the stall appears. A counter at 65535 stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rob_upd_vld | input | 1 | Reorder buffer free-count update is valid |
| rob_upd_free | input | CNT_W | Reported reorder buffer free entries |
| rob_upd_empty | input | 1 | Reported reorder-buffer-empty flag |
| iq_upd_vld | input | 1 | Issue queue free-count update is valid |
| iq_upd_free | input | CNT_W | Reported issue queue free entries |
| lsq_upd_vld | input | 1 | Load/store queue free-count update is valid |
| lsq_upd_free | input | CNT_W | Reported load/store queue free entries |
| disp_cnt | input | CNT_W | Instructions dispatched, general count |
| disp_ls_cnt | input | CNT_W | Instructions dispatched to the load/store queue |
| renamed_cnt | input | CNT_W | Instructions renamed this cycle |
| avail_cnt | input | CNT_W | Instructions waiting to be renamed |
| allow_cnt | output | CNT_W | Instructions allowed to rename (registered) |
| block_req | output | 1 | Stall request (registered) |
| limit_cause | output | 2 | Cause code of the stall (registered) |
| rob_empty | output | 1 | Stored reorder-buffer-empty flag |
| rob_full_evts | output | EV_W | Stalls caused by the reorder buffer |
| iq_full_evts | output | EV_W | Stalls caused by the issue queue |
| lsq_full_evts | output | EV_W | Stalls caused by the load/store queue |

## Verification
The bench targets exact ties among the three estimates. A design with the wrong tie order or a non-strict comparison would name the wrong cause code there. It drives different general and load/store dispatch counts, so mixing the two up shows as a wrong limit. It also pushes the in-flight count past both clamps, where an unclamped count would wrap and wrongly grant or block. A long run of stalled cycles checks that an event counter stops at 65535 and does not wrap to zero. Invalid updates carrying fresh values check that no stored count leaks through.

// File: rtl/credit_pkg.sv
package credit_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_ROB  = 2'd1,
    CAUSE_IQ   = 2'd2,
    CAUSE_LSQ  = 2'd3
  } cause_e;
  localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/credit_est.sv
module credit_est #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned EST_W = CNT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_vld,
  input  logic [CNT_W-1:0]        upd_free,
  input  logic [CNT_W-1:0]        inflight,
  input  logic [CNT_W-1:0]        drained,
  output logic signed [EST_W-1:0] est
);
  localparam int unsigned PAD = EST_W - CNT_W;

  logic [CNT_W-1:0] free_q;

  // stored free count, refreshed only by a valid report
  always_ff @(posedge clk) begin
    if (rst) free_q <= '0;
    else if (upd_vld) free_q <= upd_free;
  end

  // free minus (in flight minus drained)
  always_comb begin
    est = $signed({{PAD{1'b0}}, free_q})
        - $signed({{PAD{1'b0}}, inflight})
        + $signed({{PAD{1'b0}}, drained});
  end
endmodule

// File: rtl/credit_decide.sv
module credit_decide
  import credit_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned EST_W = CNT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [EST_W-1:0] est_rob,
  input  logic signed [EST_W-1:0] est_iq,
  input  logic signed [EST_W-1:0] est_lsq,
  input  logic [CNT_W-1:0]        avail,
  output logic [CNT_W-1:0]        allow_q,
  output logic                    block_q,
  output cause_e                  cause_q,
  output logic [NUM_SRC-1:0]      evt
);
  localparam int unsigned PAD = EST_W - CNT_W;

  logic signed [EST_W-1:0] min_v;
  logic signed [EST_W-1:0] avail_s;
  cause_e                  src;
  cause_e                  cause_d;
  logic [CNT_W-1:0]        allow_d;
  logic                    block_d;

  always_comb begin
    min_v = est_rob;
    src   = CAUSE_ROB;
    if (est_iq < min_v) begin
      min_v = est_iq;
      src   = CAUSE_IQ;
    end
    if (est_lsq < min_v) begin
      min_v = est_lsq;
      src   = CAUSE_LSQ;
    end
  end

  always_comb begin
    avail_s = $signed({{PAD{1'b0}}, avail});
    allow_d = avail;
    block_d = 1'b0;
    cause_d = CAUSE_NONE;
    if (avail == '0) begin
      allow_d = '0;
    end else if (min_v <= 0) begin
      allow_d = '0;
      block_d = 1'b1;
      cause_d = src;
    end else if (min_v < avail_s) begin
      allow_d = min_v[CNT_W-1:0];
      block_d = 1'b1;
      cause_d = src;
    end
  end

  always_comb begin
    evt = '0;
    case (cause_d)
      CAUSE_ROB: evt[0] = block_d;
      CAUSE_IQ:  evt[1] = block_d;
      CAUSE_LSQ: evt[2] = block_d;
      default:   evt    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_q <= '0;
      block_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      allow_q <= allow_d;
      block_q <= block_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/credit_evcnt.sv
module credit_evcnt #(
  parameter int unsigned EV_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  output logic [EV_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && (cnt != '1)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/credit_tracker.sv
module credit_tracker
  import credit_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned EV_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rob_upd_vld,
  input  logic [CNT_W-1:0] rob_upd_free,
  input  logic             rob_upd_empty,
  input  logic             iq_upd_vld,
  input  logic [CNT_W-1:0] iq_upd_free,
  input  logic             lsq_upd_vld,
  input  logic [CNT_W-1:0] lsq_upd_free,
  input  logic [CNT_W-1:0] disp_cnt,
  input  logic [CNT_W-1:0] disp_ls_cnt,
  input  logic [CNT_W-1:0] renamed_cnt,
  input  logic [CNT_W-1:0] avail_cnt,
  output logic [CNT_W-1:0] allow_cnt,
  output logic             block_req,
  output logic [1:0]       limit_cause,
  output logic             rob_empty,
  output logic [EV_W-1:0]  rob_full_evts,
  output logic [EV_W-1:0]  iq_full_evts,
  output logic [EV_W-1:0]  lsq_full_evts
);
  localparam int unsigned EST_W = CNT_W + 2;
  localparam logic signed [EST_W-1:0] IF_MAX = $signed({2'b00, {CNT_W{1'b1}}});

  logic [CNT_W-1:0]        inflight_q;
  logic signed [EST_W-1:0] inflight_sum;
  logic signed [EST_W-1:0] est_rob, est_iq, est_lsq;
  logic [NUM_SRC-1:0]      evt;
  logic [EV_W-1:0]         evcnt [NUM_SRC];
  cause_e                  cause_q;

  // renamed-but-not-dispatched count with clamping at both ends
  always_comb begin
    inflight_sum = $signed({2'b00, inflight_q})
                 + $signed({2'b00, renamed_cnt})
                 - $signed({2'b00, disp_cnt});
  end

  always_ff @(posedge clk) begin
    if (rst) inflight_q <= '0;
    else if (inflight_sum < 0) inflight_q <= '0;
    else if (inflight_sum > IF_MAX) inflight_q <= '1;
    else inflight_q <= inflight_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) rob_empty <= 1'b1;
    else if (rob_upd_vld) rob_empty <= rob_upd_empty;
  end

  credit_est #(.CNT_W(CNT_W), .EST_W(EST_W)) u_est_rob (
    .clk(clk), .rst(rst), .upd_vld(rob_upd_vld), .upd_free(rob_upd_free),
    .inflight(inflight_q), .drained(disp_cnt), .est(est_rob)
  );

  credit_est #(.CNT_W(CNT_W), .EST_W(EST_W)) u_est_iq (
    .clk(clk), .rst(rst), .upd_vld(iq_upd_vld), .upd_free(iq_upd_free),
    .inflight(inflight_q), .drained(disp_cnt), .est(est_iq)
  );

  credit_est #(.CNT_W(CNT_W), .EST_W(EST_W)) u_est_lsq (
    .clk(clk), .rst(rst), .upd_vld(lsq_upd_vld), .upd_free(lsq_upd_free),
    .inflight(inflight_q), .drained(disp_ls_cnt), .est(est_lsq)
  );

  credit_decide #(.CNT_W(CNT_W), .EST_W(EST_W)) u_decide (
    .clk(clk), .rst(rst), .est_rob(est_rob), .est_iq(est_iq),
    .est_lsq(est_lsq), .avail(avail_cnt), .allow_q(allow_cnt),
    .block_q(block_req), .cause_q(cause_q), .evt(evt)
  );

  assign limit_cause = cause_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_evcnt
    credit_evcnt #(.EV_W(EV_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(evt[g]), .cnt(evcnt[g])
    );
  end

  assign rob_full_evts = evcnt[0];
  assign iq_full_evts  = evcnt[1];
  assign lsq_full_evts = evcnt[2];
endmodule

// File: rtl/credit_tracker_chk.sv
module credit_tracker_chk #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned EV_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rob_upd_vld,
  input logic [CNT_W-1:0] avail_cnt,
  input logic [CNT_W-1:0] allow_cnt,
  input logic             block_req,
  input logic [1:0]       limit_cause,
  input logic             rob_empty,
  input logic [EV_W-1:0]  rob_full_evts,
  input logic [EV_W-1:0]  iq_full_evts,
  input logic [EV_W-1:0]  lsq_full_evts
);
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (avail_cnt == '0) |=> (!block_req && allow_cnt == '0 && limit_cause == 2'd0)); // R10

  AST_ALLOW_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (allow_cnt <= $past(avail_cnt))); // R8

  AST_FULL_GRANT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (!block_req && allow_cnt != '0) |-> (limit_cause == 2'd0)); // R9

  AST_EMPTY_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rob_upd_vld |=> $stable(rob_empty)); // R2

  AST_ROB_EVT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rob_full_evts) |-> (block_req && limit_cause == 2'd1)); // R11

  AST_IQ_EVT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(iq_full_evts) |-> (block_req && limit_cause == 2'd2)); // R11

  AST_LSQ_EVT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(lsq_full_evts) |-> (block_req && limit_cause == 2'd3)); // R11

  AST_EVT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (rob_full_evts == '1) |=> (rob_full_evts == '1)); // R11
endmodule

bind credit_tracker credit_tracker_chk #(.CNT_W(CNT_W), .EV_W(EV_W)) u_chk (
  .clk(clk), .rst(rst), .rob_upd_vld(rob_upd_vld), .avail_cnt(avail_cnt),
  .allow_cnt(allow_cnt), .block_req(block_req), .limit_cause(limit_cause),
  .rob_empty(rob_empty), .rob_full_evts(rob_full_evts),
  .iq_full_evts(iq_full_evts), .lsq_full_evts(lsq_full_evts)
);

// File: tb/credit_tracker_bench.sv
module credit_tracker_bench;
  localparam int CW   = 6;
  localparam int EW   = 16;
  localparam int CMAX = (1 << CW) - 1;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rv = 0, re = 0, iv = 0, lv = 0;
  logic [CW-1:0] rf = 0, iqf = 0, lf = 0, dp = 0, dl = 0, rn = 0, av = 0;
  logic [CW-1:0] allow_cnt;
  logic          block_req;
  logic [1:0]    limit_cause;
  logic          rob_empty;
  logic [EW-1:0] rob_ev, iq_ev, lsq_ev;

  always #2.5 clk = ~clk;

  credit_tracker #(.CNT_W(CW), .EV_W(EW)) u_credit_tracker (
    .clk(clk), .rst(rst),
    .rob_upd_vld(rv), .rob_upd_free(rf), .rob_upd_empty(re),
    .iq_upd_vld(iv), .iq_upd_free(iqf),
    .lsq_upd_vld(lv), .lsq_upd_free(lf),
    .disp_cnt(dp), .disp_ls_cnt(dl), .renamed_cnt(rn), .avail_cnt(av),
    .allow_cnt(allow_cnt), .block_req(block_req), .limit_cause(limit_cause),
    .rob_empty(rob_empty), .rob_full_evts(rob_ev), .iq_full_evts(iq_ev),
    .lsq_full_evts(lsq_ev)
  );

  // behavioural reference state
  int m_rf, m_iqf, m_lf, m_inf, m_emp;
  int e_allow, e_blk, e_cause;
  int m_ev[3];
  int vectors = 0, errors = 0;
  bit started = 0, finished = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    int er, ei, el, mn, src, nx;
    started = 1;
    if (rst) begin
      m_rf = 0; m_iqf = 0; m_lf = 0; m_inf = 0; m_emp = 1;
      e_allow = 0; e_blk = 0; e_cause = 0;
      for (int k = 0; k < 3; k++) m_ev[k] = 0;
    end else begin
      er = m_rf  - (m_inf - int'(dp));
      ei = m_iqf - (m_inf - int'(dp));
      el = m_lf  - (m_inf - int'(dl));
      mn = er; src = 1;
      if (ei < mn) begin mn = ei; src = 2; end
      if (el < mn) begin mn = el; src = 3; end
      if (av == 0) begin
        e_allow = 0; e_blk = 0; e_cause = 0;
      end else if (mn <= 0) begin
        e_allow = 0; e_blk = 1; e_cause = src;
      end else if (mn < int'(av)) begin
        e_allow = mn; e_blk = 1; e_cause = src;
      end else begin
        e_allow = int'(av); e_blk = 0; e_cause = 0;
      end
      if (e_blk == 1 && m_ev[e_cause-1] < EMAX) m_ev[e_cause-1]++;
      if (rv) begin m_rf = int'(rf); m_emp = int'(re); end
      if (iv) m_iqf = int'(iqf);
      if (lv) m_lf = int'(lf);
      nx = m_inf + int'(rn) - int'(dp);
      if (nx < 0) nx = 0;
      if (nx > CMAX) nx = CMAX;
      m_inf = nx;
    end
  end

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("allow_cnt", int'(allow_cnt), e_allow);
      chk("block_req", int'(block_req), e_blk);
      chk("limit_cause", int'(limit_cause), e_cause);
      chk("rob_empty", int'(rob_empty), m_emp);
      chk("rob_full_evts", int'(rob_ev), m_ev[0]);
      chk("iq_full_evts", int'(iq_ev), m_ev[1]);
      chk("lsq_full_evts", int'(lsq_ev), m_ev[2]);
    end
  end

  task automatic cyc(input bit v_r, input int f_r, input bit emp,
                     input bit v_i, input int f_i, input bit v_l, input int f_l,
                     input int d, input int d_ls, input int ren, input int a);
    rv = v_r; rf = CW'(f_r); re = emp;
    iv = v_i; iqf = CW'(f_i);
    lv = v_l; lf = CW'(f_l);
    dp = CW'(d); dl = CW'(d_ls); rn = CW'(ren); av = CW'(a);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    cur_req = "R10";
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    cur_req = "R7";                       // all estimates 0: ROB wins the tie
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    idle(1);
    cur_req = "R2";                       // load 10/10/10, empty flag cleared
    cyc(1, 10, 0, 1, 10, 1, 10, 0, 0, 0, 0);
    cur_req = "R9";
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    cur_req = "R2";                       // fresh values without valid are dropped
    cyc(0, 1, 1, 0, 1, 0, 1, 0, 0, 0, 5);
    idle(1);
    cur_req = "R3";                       // in flight grows to 8: estimates become 2
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 4, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 4, 0);
    cur_req = "R8";
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    cur_req = "R3";                       // general dispatch credits ROB and IQ
    cyc(0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 6);
    cur_req = "R4";                       // load/store dispatch only credits LSQ
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 5, 0, 7);
    cyc(0, 0, 0, 0, 0, 0, 0, 2, 1, 0, 7);
    cur_req = "R6";                       // IQ below ROB, then IQ/LSQ tie, then LSQ
    cyc(1, 20, 0, 1, 9, 1, 30, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7);
    cyc(0, 0, 0, 0, 0, 1, 9, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7);
    cyc(0, 0, 0, 0, 0, 1, 8, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7);
    cur_req = "R5";                       // lower clamp, then upper clamp
    cyc(0, 0, 0, 0, 0, 0, 0, 63, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 40, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 40, 0);
    cyc(1, 63, 1, 1, 63, 1, 63, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 63, 0, 0, 0);
    cur_req = "R6";                       // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      cyc(bit'($urandom_range(0, 1)), int'($urandom_range(0, 20)), bit'($urandom_range(0, 1)),
          bit'($urandom_range(0, 1)), int'($urandom_range(0, 20)),
          bit'($urandom_range(0, 1)), int'($urandom_range(0, 20)),
          int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
          int'($urandom_range(0, 6)), int'($urandom_range(0, 7)));
    end
    cur_req = "R11";                      // drive ROB stalls until the counter sticks
    cyc(1, 0, 0, 1, 5, 1, 5, 63, 63, 0, 0);
    for (int i = 0; i < 65600; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("rob_full_evts saturated", int'(rob_ev), EMAX);
    cur_req = "R1";                       // reset mid-run clears everything
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);
    chk("rob_empty after reset", int'(rob_empty), 1);
    chk("rob_full_evts after reset", int'(rob_ev), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog %s: got timeout expected completion", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule